// File: doc/BRIEF.md
# Interrupt Vector Mapping Unit

This block turns interrupt requests from an I/O device into interrupt packets for the processor crossbar. Each request carries a command code and a 7-bit device ID. When the command marks an interrupt, the device ID indexes a table that software fills in. The table entry names the CPU thread that should take the interrupt and the vector it should see. The block packs those two fields into a wide, mostly-zero packet with a fixed layout and presents it on the output bus.

A request is taken on a rising edge of the input valid, not on its level. The table read is registered, so the thread and vector are latched two clock edges after the request is accepted. The packet stays on the output until the crossbar side accepts it. While a lookup or an unaccepted packet is in flight, `req_ready` is held low. A request raised during that time waits and is taken once the block is free again.

Top module: `intr_map_top`

## Requirements
- R1: After synchronous reset, `pkt_valid` is low, `req_ready` is high, and every table entry reads as zero.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are high and `req_valid` has been low at some edge since the previous acceptance. Holding `req_valid` high never produces a second request.
- R3: An accepted request is an interrupt only when `req_data[3:0]` equals 4'h8. Any other code produces no packet and leaves `req_ready` high.
- R4: The device ID is `req_data[16:10]` of the accepted request. All other bits of `req_data` above bit 3 do not affect the packet.
- R5: A table write stores `tbl_wr_data` at `tbl_wr_addr` on an edge where `tbl_wr_en` is high. In an entry, bits [11:6] are the thread ID and bits [5:0] the vector. Bits [15:12] are ignored.
- R6: If a write hits the entry being read at the same edge, the packet carries the entry's old contents. Later reads see the new contents.
- R7: The packet sets bit 145 to 1 and bits [144:141] to 4'b0111. Bits [136:134] hold thread[2:0], bits [13:8] hold the full thread ID, and bits [5:0] hold the vector. Every other bit, including the error field [139:138] and the type field [15:14], is zero.
- R8: `pkt_valid` rises at the second clock edge after the edge that accepted the interrupt.
- R9: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid` and `pkt_data` hold their values. The edge where both are high clears `pkt_valid`.
- R10: `req_ready` is low from the edge that accepts an interrupt until the edge that hands off its packet. A request raised during that time is accepted at the first edge after `req_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr_en | input | 1 | Table write enable |
| tbl_wr_addr | input | 7 | Table write index |
| tbl_wr_data | input | 16 | Table write data: thread in [11:6], vector in [5:0] |
| req_valid | input | 1 | Device request valid (edge-detected) |
| req_data | input | 32 | Request word: command [3:0], device ID [16:10] |
| req_ready | output | 1 | High when a new request can be taken |
| pkt_valid | output | 1 | Output packet valid |
| pkt_ready | input | 1 | Crossbar accepts the packet |
| pkt_data | output | 146 | Assembled interrupt packet |

## Verification
The hardest case to reach is a table write that lands on the very entry being read, at the single edge where the registered read takes place. The bench raises a request at one falling edge. At the next falling edge it drives a write to the same index, so the write and the read share the following rising edge. It then checks that the packet holds the old entry and that a second request sees the new one. A second hard case is a request that arrives while an earlier packet is blocked. The bench holds `pkt_ready` low, drops and re-raises `req_valid` with a new device ID, and checks that the held packet stays unchanged. It then releases the handshake and times the pending request through to its own packet.

// File: rtl/intr_map_pkg.sv
package intr_map_pkg;

    localparam int ENTRY_W    = 16;
    localparam int THR_W      = 6;
    localparam int VEC_W      = 6;
    localparam int DEV_W      = 7;
    localparam int CMD_W      = 4;
    localparam int DEV_LSB    = 10;
    localparam logic [CMD_W-1:0] CMD_INTR = 4'h8;

    // Output packet layout
    localparam int PKT_W       = 146;
    localparam int PKT_VLD_BIT = 145;
    localparam int RTYPE_LSB   = 141;
    localparam int ERR_LSB     = 138;
    localparam int THRLO_LSB   = 134;
    localparam int TYPE_LSB    = 14;
    localparam int THR_LSB     = 8;
    localparam int VEC_LSB     = 0;
    localparam logic [3:0] RTYPE_INTR = 4'b0111;
    localparam logic [1:0] ERR_NONE   = 2'b00;
    localparam logic [1:0] TYPE_INTR  = 2'b00;

    typedef struct packed {
        logic [3:0]       spare;
        logic [THR_W-1:0] thread;
        logic [VEC_W-1:0] vector;
    } map_entry_t;

    typedef struct packed {
        logic             is_intr;
        logic [DEV_W-1:0] dev;
    } req_fields_t;

    function automatic req_fields_t decode_req(input logic [CMD_W-1:0] cmd,
                                               input logic [DEV_W-1:0] dev);
        req_fields_t r;
        r.is_intr = (cmd == CMD_INTR);
        r.dev     = dev;
        return r;
    endfunction

    function automatic logic [PKT_W-1:0] pack_intr(input map_entry_t e);
        logic [PKT_W-1:0] p;
        p = '0;
        p[PKT_VLD_BIT]         = 1'b1;
        p[RTYPE_LSB +: 4]      = RTYPE_INTR;
        p[ERR_LSB +: 2]        = ERR_NONE;
        p[THRLO_LSB +: 3]      = e.thread[2:0];
        p[TYPE_LSB +: 2]       = TYPE_INTR;
        p[THR_LSB +: THR_W]    = e.thread;
        p[VEC_LSB +: VEC_W]    = e.vector;
        return p;
    endfunction

endpackage

// File: rtl/intr_req_detect.sv
module intr_req_detect
    import intr_map_pkg::*;
#(
    parameter int REQ_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [REQ_W-1:0] req_data,
    input  logic             busy,
    output logic             req_ready,
    output logic             int_accept,
    output logic [DEV_W-1:0] dev_id
);

    logic        armed_q;
    logic        accept;
    req_fields_t fields;

    assign fields     = decode_req(req_data[CMD_W-1:0], req_data[DEV_LSB +: DEV_W]);
    assign req_ready  = ~busy;
    assign accept     = req_valid & armed_q & req_ready;
    assign int_accept = accept & fields.is_intr;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
            dev_id  <= '0;
        end else begin
            if (accept) begin
                armed_q <= 1'b0;
                dev_id  <= fields.dev;
            end else if (!req_valid) begin
                armed_q <= 1'b1;
            end
        end
    end

    // R2: a held valid level cannot be accepted twice in a row
    p_single_accept_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);

endmodule

// File: rtl/intr_map_table.sv
module intr_map_table
    import intr_map_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [AW-1:0] wr_addr,
    input  map_entry_t wr_data,
    input  logic       rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic       rd_pending,
    output logic       rd_valid,
    output map_entry_t rd_entry
);

    map_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read: sees contents before any write at the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pending <= 1'b0;
            rd_valid   <= 1'b0;
            rd_entry   <= '0;
        end else begin
            rd_pending <= rd_req;
            rd_valid   <= rd_pending;
            if (rd_pending) begin
                rd_entry <= mem[rd_addr];
            end
        end
    end

    // R5: write index must be known when writing
    p_wr_addr_known_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !$isunknown(wr_addr));

endmodule

// File: rtl/intr_pkt_out.sv
module intr_pkt_out
    import intr_map_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  map_entry_t       entry,
    input  logic             pkt_ready,
    output logic             pkt_valid,
    output logic [PKT_W-1:0] pkt_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_valid <= 1'b0;
            pkt_data  <= '0;
        end else if (load) begin
            pkt_valid <= 1'b1;
            pkt_data  <= pack_intr(entry);
        end else if (pkt_valid && pkt_ready) begin
            pkt_valid <= 1'b0;
        end
    end

    // R9: held packet stays put until accepted
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data)));

    // R9: handshake releases the packet
    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_ready && !load) |=> !pkt_valid);

endmodule

// File: rtl/intr_map_top.sv
module intr_map_top
    import intr_map_pkg::*;
#(
    parameter int TBL_DEPTH = 128,
    parameter int REQ_W     = 32,
    localparam int TBL_AW   = $clog2(TBL_DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tbl_wr_en,
    input  logic [TBL_AW-1:0]  tbl_wr_addr,
    input  logic [ENTRY_W-1:0] tbl_wr_data,
    input  logic               req_valid,
    input  logic [REQ_W-1:0]   req_data,
    output logic               req_ready,
    output logic               pkt_valid,
    input  logic               pkt_ready,
    output logic [PKT_W-1:0]   pkt_data
);

    logic             int_accept;
    logic [DEV_W-1:0] dev_id;
    logic             rd_pending;
    logic             rd_valid;
    map_entry_t       rd_entry;
    logic             busy;

    assign busy = rd_pending | rd_valid | pkt_valid;

    intr_req_detect #(.REQ_W(REQ_W)) u_detect (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_data   (req_data),
        .busy       (busy),
        .req_ready  (req_ready),
        .int_accept (int_accept),
        .dev_id     (dev_id)
    );

    intr_map_table #(.DEPTH(TBL_DEPTH)) u_table (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (tbl_wr_en),
        .wr_addr    (tbl_wr_addr),
        .wr_data    (map_entry_t'(tbl_wr_data)),
        .rd_req     (int_accept),
        .rd_addr    (dev_id[TBL_AW-1:0]),
        .rd_pending (rd_pending),
        .rd_valid   (rd_valid),
        .rd_entry   (rd_entry)
    );

    intr_pkt_out u_out (
        .clk        (clk),
        .rst        (rst),
        .load       (rd_valid),
        .entry      (rd_entry),
        .pkt_ready  (pkt_ready),
        .pkt_valid  (pkt_valid),
        .pkt_data   (pkt_data)
    );

    // R8: finished lookup becomes a valid packet at the next edge
    p_lookup_to_pkt_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> pkt_valid);

    // R10: no request taken while a packet waits
    p_stall_r10: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> !req_ready);

    // R10: accepted interrupt drops ready for the lookup
    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
        int_accept |=> !req_ready);

    // R7: packet valid bit always set while presented
    p_pkt_marker_r7: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> pkt_data[PKT_VLD_BIT]);

endmodule

// File: tb/intr_map_top_tb.sv
`timescale 1ns/1ps
module intr_map_top_tb;

    localparam int PW = 146;

    typedef struct packed {
        logic [6:0]  dev;
        logic [15:0] entry;
        logic [3:0]  cmd;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{dev: 7'd0,   entry: 16'h0FFF, cmd: 4'h8},
        '{dev: 7'd127, entry: 16'hF5A3, cmd: 4'h8},
        '{dev: 7'd64,  entry: 16'h0041, cmd: 4'h8},
        '{dev: 7'd3,   entry: 16'h0123, cmd: 4'h9},
        '{dev: 7'd42,  entry: 16'h3ABC, cmd: 4'h8},
        '{dev: 7'd1,   entry: 16'h0777, cmd: 4'h0}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          tbl_wr_en;
    logic [6:0]    tbl_wr_addr;
    logic [15:0]   tbl_wr_data;
    logic          req_valid;
    logic [31:0]   req_data;
    logic          req_ready;
    logic          pkt_valid;
    logic          pkt_ready;
    logic [PW-1:0] pkt_data;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    intr_map_top u_dut (
        .clk         (clk),
        .rst         (rst),
        .tbl_wr_en   (tbl_wr_en),
        .tbl_wr_addr (tbl_wr_addr),
        .tbl_wr_data (tbl_wr_data),
        .req_valid   (req_valid),
        .req_data    (req_data),
        .req_ready   (req_ready),
        .pkt_valid   (pkt_valid),
        .pkt_ready   (pkt_ready),
        .pkt_data    (pkt_data)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [PW-1:0] expect_pkt(input logic [15:0] e);
        logic [PW-1:0] p;
        p = '0;
        p[145]     = 1'b1;
        p[144:141] = 4'b0111;
        p[136:134] = e[8:6];
        p[13:8]    = e[11:6];
        p[5:0]     = e[5:0];
        return p;
    endfunction

    task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_entry(input logic [6:0] a, input logic [15:0] d);
        tbl_wr_en   = 1'b1;
        tbl_wr_addr = a;
        tbl_wr_data = d;
        @(negedge clk);
        tbl_wr_en   = 1'b0;
    endtask

    task automatic wait_pkt(output int lat);
        lat = 0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (pkt_valid) begin
                lat = i;
                break;
            end
        end
    endtask

    // Junk in bits [31:17] and [9:4] must not matter (R4)
    task automatic send(input logic [6:0] dev, input logic [3:0] cmd, input bit drop, output int lat);
        req_data  = {15'h5A5A, dev, 6'h2B, cmd};
        req_valid = 1'b1;
        lat = 0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (i == 1 && drop) req_valid = 1'b0;
            if (pkt_valid) begin
                lat = i;
                break;
            end
        end
    endtask

    task automatic pop();
        pkt_ready = 1'b1;
        @(negedge clk);
        pkt_ready = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int lat;
        logic [PW-1:0] held;
        rst = 1'b1; tbl_wr_en = 0; tbl_wr_addr = 0; tbl_wr_data = 0;
        req_valid = 0; req_data = 0; pkt_ready = 0;
        @(negedge clk);
        do_reset();

        // R1: reset state at the ports
        chk("R1 pkt_valid", PW'(pkt_valid), PW'(0));
        chk("R1 req_ready", PW'(req_ready), PW'(1));
        send(7'd5, 4'h8, 1, lat);
        chk("R1 cleared entry", pkt_data, expect_pkt(16'h0000));
        pop();

        // R1: reset clears an entry written earlier
        write_entry(7'd9, 16'h0ABC);
        do_reset();
        send(7'd9, 4'h8, 1, lat);
        chk("R1 entry cleared by reset", pkt_data, expect_pkt(16'h0000));
        pop();

        // Vector walk: R3 R4 R5 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            write_entry(VECS[v].dev, VECS[v].entry);
            send(VECS[v].dev, VECS[v].cmd, 1, lat);
            if (VECS[v].cmd == 4'h8) begin
                chk("R8 latency", PW'(lat), PW'(3));
                chk("R7 R5 R4 packet", pkt_data, expect_pkt(VECS[v].entry));
                pop();
                chk("R9 released", PW'(pkt_valid), PW'(0));
            end else begin
                chk("R3 no packet", PW'(lat), PW'(0));
                chk("R3 ready stays", PW'(req_ready), PW'(1));
            end
        end

        // R2: level held high gives one packet only
        write_entry(7'd17, 16'h0155);
        send(7'd17, 4'h8, 0, lat);
        chk("R2 first packet", pkt_data, expect_pkt(16'h0155));
        pop();
        wait_pkt(lat);
        chk("R2 no repeat on level", PW'(lat), PW'(0));
        req_valid = 1'b0;
        @(negedge clk);

        // R6: write to the entry at the edge it is read
        write_entry(7'd20, 16'h0208);
        req_data  = {15'h0, 7'd20, 6'h0, 4'h8};
        req_valid = 1'b1;
        @(negedge clk);
        req_valid   = 1'b0;
        tbl_wr_en   = 1'b1;
        tbl_wr_addr = 7'd20;
        tbl_wr_data = 16'h0F3E;
        @(negedge clk);
        tbl_wr_en   = 1'b0;
        @(negedge clk);
        chk("R6 valid", PW'(pkt_valid), PW'(1));
        chk("R6 old contents", pkt_data, expect_pkt(16'h0208));
        pop();
        send(7'd20, 4'h8, 1, lat);
        chk("R6 new contents later", pkt_data, expect_pkt(16'h0F3E));
        pop();

        // R10 / R9: request during a blocked packet
        write_entry(7'd10, 16'h00C7);
        write_entry(7'd11, 16'h0E19);
        send(7'd10, 4'h8, 1, lat);
        held = pkt_data;
        chk("R10 ready low while held", PW'(req_ready), PW'(0));
        req_data  = {15'h0, 7'd11, 6'h0, 4'h8};
        req_valid = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 held packet stable", pkt_data, held);
        chk("R9 still valid", PW'(pkt_valid), PW'(1));
        chk("R10 still stalled", PW'(req_ready), PW'(0));
        pop();
        chk("R10 ready back", PW'(req_ready), PW'(1));
        wait_pkt(lat);
        req_valid = 1'b0;
        chk("R10 pending accepted", PW'(lat), PW'(3));
        chk("R10 pending packet", pkt_data, expect_pkt(16'h0E19));
        pop();
        chk("R9 final release", PW'(pkt_valid), PW'(0));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule